// File: doc/BRIEF.md
# Hashed page table walker

This block resolves a 32-bit effective address through a hashed page table held in ordinary memory. It is used after the block-address translation has missed. A client presents the address, a side flag (data or instruction), a store flag, the sixteen segment VSID values and the table register. The walker then reads translation entries one word at a time over a request/response memory port. It searches the primary 64-byte group first and then the secondary group. When a first word matches, it returns the composed physical address. Otherwise it reports a translation fault, with status bits and the faulting address.

The same engine also serves an insert request. An insert scans the same sixteen slots in the same order, looking for an entry whose valid bit is clear. It writes the new entry's two words there. If every slot is occupied, the insert reports failure. A busy/done pair frames each request, and only one request runs at a time.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a request.
- `ST_RD_KEY` and `ST_WT_KEY`: issue and await the first-word read of the current slot.
- `ST_RD_LO` and `ST_WT_LO`: fetch the second word of the matched entry.
- `ST_WR_KEY` and `ST_WR_LO`: write the two words of an inserted entry.
- `ST_DONE`: presents the result for one cycle.

The transitions are:
- Accept: `ST_IDLE` goes to `ST_RD_KEY`, or straight to `ST_DONE` when the table register is zero.
- Issue: `ST_RD_KEY` goes to `ST_WT_KEY` when the read is taken.
- Hit: `ST_WT_KEY` goes to `ST_RD_LO` (walk) when the first word matches.
- Free: `ST_WT_KEY` goes to `ST_WR_KEY` (insert) when the slot's valid bit is clear.
- Step: `ST_WT_KEY` goes back to `ST_RD_KEY` with the next slot.
- Exhaust: `ST_WT_KEY` goes to `ST_DONE` after the sixteenth slot.
- `ST_RD_LO` goes to `ST_WT_LO`, and `ST_WT_LO` goes to `ST_DONE`.
- `ST_WR_KEY` goes to `ST_WR_LO`, and `ST_WR_LO` goes to `ST_DONE`.
- Release: `ST_DONE` goes to `ST_IDLE`.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req_valid` are low. `resp_far` and `resp_status` are zero.
- R2: The table register holds the table base in bits [31:16] and a 9-bit group mask in bits [8:0]. With VSID = segment VSID selected by `req_ea[31:28]` and h = (`req_ea[27:12]` XOR VSID) truncated to 23 bits, the primary group address is base + (h[9:0] << 6) + ((h[22:10] AND mask) << 16). The secondary group uses the bitwise complement of h in the same formula.
- R3: Slots are read in a fixed order: primary slots 0 to 7 at group + 8*i, then secondary slots 0 to 7. Each slot costs one first-word read.
- R4: The walk compare key is bit 31 set, VSID in bits [30:7], H in bit 6 (0 primary, 1 secondary) and `req_ea[27:22]` in bits [5:0]. The first slot whose first word equals the key ends the search. One more read at slot address + 4 then fetches the second word.
- R5: On a hit, `resp_ok` is set. `resp_pa[31:12]` is second word [31:12], and `resp_pa[11:0]` is `req_ea[11:0]`. `resp_pa[32]` is second word bit 2, and `resp_pa[35:33]` is second word [11:9].
- R6: A walk that misses all sixteen slots sets `resp_fault`. For a data-side walk, `resp_status` bit 0 (no translation) is 1, bit 1 equals `req_write`, and `resp_far` takes `req_ea`. For an instruction-side walk, `resp_status` is 0 and `resp_far` keeps its value.
- R7: A request taken while the table register is zero faults with no memory traffic. The status and faulting-address rules of R6 apply.
- R8: An insert (`req_op` = 1) writes to the first slot, in R3 order, whose first word has bit 31 clear. It writes the R4 key, with H matching the group used, at the slot address. It then writes `req_lo_word` at slot address + 4, and sets `resp_ok`.
- R9: An insert that finds all sixteen slots valid sets `resp_fault` with `resp_status` = 0, and it writes nothing.
- R10: A request is taken only while `busy` is low; one raised while busy is ignored. Each taken request yields exactly one single-cycle `done` pulse, with exactly one of `resp_ok` and `resp_fault` set.
- R11: A memory request, once raised, holds its address, data and direction until `mem_req_ready`. At most one read is outstanding. Every memory access belongs to the walk or insert in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_op | input | 1 | 0 walk, 1 insert |
| req_ea | input | 32 | Effective address |
| req_data_side | input | 1 | 1 data-side access, 0 instruction-side |
| req_write | input | 1 | Access was a store |
| req_lo_word | input | 32 | Second word written by an insert |
| seg_vsid | input | NUM_SEG*VSID_W | Segment VSIDs, segment i in slice i |
| tbl_reg | input | 32 | Table base [31:16] and group mask [8:0] |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_ok | output | 1 | Walk hit or insert written |
| resp_fault | output | 1 | Walk miss, zero table or no free slot |
| resp_status | output | 2 | Bit 0 no translation, bit 1 store |
| resp_far | output | 32 | Last data-side faulting address |
| resp_pa | output | PA_W | Physical address of a hit |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The hardest outcomes to reach from the ports depend on the table's contents rather than on the request. One is a hit in the secondary group, which needs all eight primary slots occupied by non-matching entries. Another is an insert that finds both groups full. A third is a miss whose first word differs from a resident entry only in the address-tag field. The bench reaches these by writing entries straight into its memory model, chosen so that two addresses share both groups while differing in tag bits. It then predicts every read and write address in order and compares the whole access trace of each request. The memory model also stalls `mem_req_ready` and delays responses pseudo-randomly, so that handshake holding is exercised.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_KEY,
        ST_WT_KEY,
        ST_RD_LO,
        ST_WT_LO,
        ST_WR_KEY,
        ST_WR_LO,
        ST_DONE
    } hpt_state_e;

    localparam logic OP_WALK   = 1'b0;
    localparam logic OP_INSERT = 1'b1;

    localparam int ADDR_W          = 32;
    localparam int WORD_W          = 32;
    localparam int HASH_W          = 23;
    localparam int HASH_LO_W       = 10;
    localparam int MASK_W          = 9;
    localparam int BASE_W          = 16;
    localparam int GROUP_SHIFT     = 6;
    localparam int HIGH_SHIFT      = 16;
    localparam int ENTRY_SHIFT     = 3;
    localparam int SLOTS_PER_GROUP = 8;
    localparam int NUM_GROUPS      = 2;
    localparam int SLOT_W          = $clog2(SLOTS_PER_GROUP * NUM_GROUPS);
    localparam int IDX_W           = $clog2(SLOTS_PER_GROUP);
    localparam int API_W           = 6;
    localparam int PAGE_W          = 12;
    localparam int RPN_W           = 20;
    localparam int XPN_W           = 3;
    localparam int PA_W            = ADDR_W + 1 + XPN_W;

endpackage

// File: rtl/hpt_seg_select.sv
module hpt_seg_select #(
    parameter int NUM_SEG = 16,
    parameter int VSID_W  = 24,
    localparam int SEG_W  = $clog2(NUM_SEG)
) (
    input  logic [NUM_SEG*VSID_W-1:0] seg_vsid,
    input  logic [SEG_W-1:0]          seg_idx,
    output logic [VSID_W-1:0]         vsid
);
    always_comb begin
        vsid = seg_vsid[seg_idx*VSID_W +: VSID_W];
    end
endmodule

// File: rtl/hpt_hash_calc.sv
module hpt_hash_calc
    import hpt_pkg::*;
#(
    parameter int VSID_W    = 24,
    parameter int SECONDARY = 0
) (
    input  logic [BASE_W-1:0] base,
    input  logic [MASK_W-1:0] mask,
    input  logic [15:0]       page_idx,
    input  logic [API_W-1:0]  api,
    input  logic [VSID_W-1:0] vsid,
    output logic [ADDR_W-1:0] group_addr,
    output logic [WORD_W-1:0] key
);
    localparam int HI_W = HASH_W - HASH_LO_W;
    localparam logic H_BIT = (SECONDARY != 0);

    logic [HASH_W-1:0] h_raw;
    logic [HASH_W-1:0] h;
    logic [HI_W-1:0]   hi_sel;
    logic [ADDR_W-1:0] lo_off;
    logic [ADDR_W-1:0] hi_off;

    always_comb begin
        h_raw  = {{(HASH_W-16){1'b0}}, page_idx} ^ vsid[HASH_W-1:0];
        h      = H_BIT ? ~h_raw : h_raw;
        hi_sel = h[HASH_W-1:HASH_LO_W] & {{(HI_W-MASK_W){1'b0}}, mask};
        lo_off = {{(ADDR_W-HASH_LO_W){1'b0}}, h[HASH_LO_W-1:0]} << GROUP_SHIFT;
        hi_off = {{(ADDR_W-HI_W){1'b0}}, hi_sel} << HIGH_SHIFT;
        group_addr = {base, {(ADDR_W-BASE_W){1'b0}}} + (lo_off | hi_off);
        key = {1'b1, vsid, H_BIT, api};
    end
endmodule

// File: rtl/hpt_pa_build.sv
module hpt_pa_build
    import hpt_pkg::*;
(
    input  logic [RPN_W-1:0]  rpn,
    input  logic [XPN_W-1:0]  xpn,
    input  logic              xbit,
    input  logic [PAGE_W-1:0] page_off,
    output logic [PA_W-1:0]   pa
);
    always_comb begin
        pa = {xpn, xbit, rpn, page_off};
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int NUM_SEG = 16,
    parameter int VSID_W  = 24,
    localparam int SEG_W  = $clog2(NUM_SEG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_op,
    input  logic [ADDR_W-1:0]         req_ea,
    input  logic                      req_data_side,
    input  logic                      req_write,
    input  logic [WORD_W-1:0]         req_lo_word,
    input  logic [NUM_SEG*VSID_W-1:0] seg_vsid,
    input  logic [WORD_W-1:0]         tbl_reg,
    output logic                      busy,
    output logic                      done,
    output logic                      resp_ok,
    output logic                      resp_fault,
    output logic [1:0]                resp_status,
    output logic [ADDR_W-1:0]         resp_far,
    output logic [PA_W-1:0]           resp_pa,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic                      mem_req_we,
    output logic [ADDR_W-1:0]         mem_req_addr,
    output logic [WORD_W-1:0]         mem_req_wdata,
    input  logic                      mem_rsp_valid,
    input  logic [WORD_W-1:0]         mem_rsp_rdata
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;
    localparam logic [ADDR_W-1:0] HI_WORD   = ADDR_W'(WORD_W / 8);

    hpt_state_e state_q, state_d;

    logic              op_q, side_q, wr_q;
    logic [ADDR_W-1:0] ea_q;
    logic [WORD_W-1:0] lo_q;
    logic [VSID_W-1:0] vsid_q;
    logic [BASE_W-1:0] base_q;
    logic [MASK_W-1:0] mask_q;
    logic [SLOT_W-1:0] slot_q;
    logic              ok_q, fault_q;
    logic [1:0]        status_q;
    logic [ADDR_W-1:0] far_q;
    logic [PA_W-1:0]   pa_q;

    logic              accept, tbl_zero;
    logic              slot_step, miss_end, lo_capture, ins_end;
    logic [VSID_W-1:0] vsid_sel;
    logic [ADDR_W-1:0] grp_addr [NUM_GROUPS];
    logic [WORD_W-1:0] grp_key  [NUM_GROUPS];
    logic [ADDR_W-1:0] grp_cur, slot_addr;
    logic [WORD_W-1:0] key_cur;
    logic [PA_W-1:0]   pa_new;
    logic              key_hit, slot_free;

    hpt_seg_select #(.NUM_SEG(NUM_SEG), .VSID_W(VSID_W)) u_seg (
        .seg_vsid (seg_vsid),
        .seg_idx  (req_ea[ADDR_W-1 -: SEG_W]),
        .vsid     (vsid_sel)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hash
        hpt_hash_calc #(.VSID_W(VSID_W), .SECONDARY(g)) u_hash (
            .base       (base_q),
            .mask       (mask_q),
            .page_idx   (ea_q[27:12]),
            .api        (ea_q[27:22]),
            .vsid       (vsid_q),
            .group_addr (grp_addr[g]),
            .key        (grp_key[g])
        );
    end

    hpt_pa_build u_pa (
        .rpn      (mem_rsp_rdata[WORD_W-1 -: RPN_W]),
        .xpn      (mem_rsp_rdata[11:9]),
        .xbit     (mem_rsp_rdata[2]),
        .page_off (ea_q[PAGE_W-1:0]),
        .pa       (pa_new)
    );

    always_comb begin
        accept    = req_valid && (state_q == ST_IDLE);
        tbl_zero  = (tbl_reg == '0);
        grp_cur   = grp_addr[slot_q[SLOT_W-1]];
        key_cur   = grp_key[slot_q[SLOT_W-1]];
        slot_addr = grp_cur + ({{(ADDR_W-IDX_W){1'b0}}, slot_q[IDX_W-1:0]} << ENTRY_SHIFT);
        key_hit   = (op_q == OP_WALK) && (mem_rsp_rdata == key_cur);
        slot_free = (op_q == OP_INSERT) && !mem_rsp_rdata[WORD_W-1];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and step strobes
    always_comb begin
        state_d    = state_q;
        slot_step  = 1'b0;
        miss_end   = 1'b0;
        lo_capture = 1'b0;
        ins_end    = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = tbl_zero ? ST_DONE : ST_RD_KEY;
            ST_RD_KEY: if (mem_req_ready) state_d = ST_WT_KEY;
            ST_WT_KEY: begin
                if (mem_rsp_valid) begin
                    if (key_hit)                  state_d = ST_RD_LO;
                    else if (slot_free)           state_d = ST_WR_KEY;
                    else if (slot_q == LAST_SLOT) begin
                        miss_end = 1'b1;
                        state_d  = ST_DONE;
                    end else begin
                        slot_step = 1'b1;
                        state_d   = ST_RD_KEY;
                    end
                end
            end
            ST_RD_LO:  if (mem_req_ready) state_d = ST_WT_LO;
            ST_WT_LO: begin
                if (mem_rsp_valid) begin
                    lo_capture = 1'b1;
                    state_d    = ST_DONE;
                end
            end
            ST_WR_KEY: if (mem_req_ready) state_d = ST_WR_LO;
            ST_WR_LO: begin
                if (mem_req_ready) begin
                    ins_end = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_DONE);
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = slot_addr;
        mem_req_wdata = key_cur;
        unique case (state_q)
            ST_RD_KEY: mem_req_valid = 1'b1;
            ST_RD_LO: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = slot_addr + HI_WORD;
            end
            ST_WR_KEY: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
            end
            ST_WR_LO: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = slot_addr + HI_WORD;
                mem_req_wdata = lo_q;
            end
            ST_IDLE, ST_WT_KEY, ST_WT_LO, ST_DONE: mem_req_valid = 1'b0;
            default: mem_req_valid = 1'b0;
        endcase
        resp_ok     = ok_q;
        resp_fault  = fault_q;
        resp_status = status_q;
        resp_far    = far_q;
        resp_pa     = pa_q;
    end

    // Request context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_WALK;
            ea_q     <= '0;
            side_q   <= 1'b0;
            wr_q     <= 1'b0;
            lo_q     <= '0;
            vsid_q   <= '0;
            base_q   <= '0;
            mask_q   <= '0;
            slot_q   <= '0;
            ok_q     <= 1'b0;
            fault_q  <= 1'b0;
            status_q <= '0;
            far_q    <= '0;
            pa_q     <= '0;
        end else if (accept) begin
            op_q     <= req_op;
            ea_q     <= req_ea;
            side_q   <= req_data_side;
            wr_q     <= req_write;
            lo_q     <= req_lo_word;
            vsid_q   <= vsid_sel;
            base_q   <= tbl_reg[WORD_W-1 -: BASE_W];
            mask_q   <= tbl_reg[MASK_W-1:0];
            slot_q   <= '0;
            ok_q     <= 1'b0;
            fault_q  <= tbl_zero;
            status_q <= '0;
            if (tbl_zero && (req_op == OP_WALK) && req_data_side) begin
                status_q <= {req_write, 1'b1};
                far_q    <= req_ea;
            end
        end else if (slot_step) begin
            slot_q <= slot_q + 1'b1;
        end else if (miss_end) begin
            fault_q <= 1'b1;
            if ((op_q == OP_WALK) && side_q) begin
                status_q <= {wr_q, 1'b1};
                far_q    <= ea_q;
            end
        end else if (lo_capture) begin
            ok_q <= 1'b1;
            pa_q <= pa_new;
        end else if (ins_end) begin
            ok_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_op,
    input logic        req_data_side,
    input logic        busy,
    input logic        done,
    input logic        resp_ok,
    input logic        resp_fault,
    input logic [1:0]  resp_status,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_we,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid
);
    logic rd_out_q;
    logic op_ins_q;
    logic side_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_out_q <= 1'b0;
            op_ins_q <= 1'b0;
            side_q   <= 1'b0;
        end else begin
            if (req_valid && !busy) begin
                op_ins_q <= req_op;
                side_q   <= req_data_side;
            end
            if (mem_req_valid && mem_req_ready && !mem_req_we) rd_out_q <= 1'b1;
            else if (mem_rsp_valid)                             rd_out_q <= 1'b0;
        end
    end

    p_busy_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({resp_ok, resp_fault}) == 1));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_q |-> !mem_req_valid);

    p_traffic_in_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    p_write_only_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> op_ins_q);

    p_ifetch_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resp_fault && !side_q && !op_ins_q) |-> (resp_status == 2'b00));

    p_insert_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_ins_q) |-> (resp_status == 2'b00));

endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_data_side (req_data_side),
    .busy          (busy),
    .done          (done),
    .resp_ok       (resp_ok),
    .resp_fault    (resp_fault),
    .resp_status   (resp_status),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
    localparam int NUM_SEG = 16;
    localparam int VSID_W  = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_data_side = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_lo_word = '0;
    logic [NUM_SEG*VSID_W-1:0] seg_vsid;
    logic [31:0] tbl_reg = '0;
    logic        busy, done, resp_ok, resp_fault;
    logic [1:0]  resp_status;
    logic [31:0] resp_far;
    logic [35:0] resp_pa;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #10 clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ea(req_ea), .req_data_side(req_data_side), .req_write(req_write),
        .req_lo_word(req_lo_word), .seg_vsid(seg_vsid), .tbl_reg(tbl_reg),
        .busy(busy), .done(done), .resp_ok(resp_ok), .resp_fault(resp_fault),
        .resp_status(resp_status), .resp_far(resp_far), .resp_pa(resp_pa),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit cond, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Bench memory and traces
    bit [31:0] mem_q [bit [31:0]];
    logic [32:0] act_trace [$];
    logic [32:0] exp_trace [$];

    function automatic bit [31:0] mrd(input bit [31:0] a);
        return mem_q.exists(a) ? mem_q[a] : 32'h0;
    endfunction

    logic [23:0] seg_v [NUM_SEG];
    always_comb begin
        for (int i = 0; i < NUM_SEG; i++) seg_vsid[i*VSID_W +: VSID_W] = seg_v[i];
    end

    function automatic logic [31:0] grp(input logic [31:0] ea, input bit sec);
        logic [23:0] v;
        logic [22:0] h;
        logic [12:0] hi;
        v  = seg_v[ea[31:28]];
        h  = {7'b0, ea[27:12]} ^ v[22:0];
        if (sec) h = ~h;
        hi = h[22:10] & {4'b0, tbl_reg[8:0]};
        return {tbl_reg[31:16], 16'h0} + ({22'b0, h[9:0]} << 6) + ({19'b0, hi} << 16);
    endfunction

    function automatic logic [31:0] kval(input logic [31:0] ea, input bit sec);
        return {1'b1, seg_v[ea[31:28]], sec, ea[27:22]};
    endfunction

    typedef struct packed {
        logic        walk;
        logic        ok;
        logic        fault;
        logic [1:0]  status;
        logic [31:0] far;
        logic [35:0] pa;
        logic [7:0]  n_acc;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    logic [31:0] model_far = '0;

    task automatic expect_req(input bit is_walk, input logic [31:0] ea,
                              input bit side, input bit wr, input string tag);
        exp_t e;
        bit found;
        logic [31:0] a, w;
        e = '0;
        e.walk = is_walk;
        found = 1'b0;
        if (tbl_reg != 0) begin
            for (int s = 0; s < 2 && !found; s++) begin
                for (int i = 0; i < 8 && !found; i++) begin
                    a = grp(ea, s[0]) + 32'(i * 8);
                    exp_trace.push_back({1'b0, a});
                    e.n_acc++;
                    if (is_walk && mrd(a) == kval(ea, s[0])) begin
                        found = 1'b1;
                        exp_trace.push_back({1'b0, a + 32'd4});
                        e.n_acc++;
                        w = mrd(a + 32'd4);
                        e.pa = {w[11:9], w[2], w[31:12], ea[11:0]};
                    end else if (!is_walk && !mrd(a)[31]) begin
                        found = 1'b1;
                        exp_trace.push_back({1'b1, a});
                        exp_trace.push_back({1'b1, a + 32'd4});
                        e.n_acc += 2;
                    end
                end
            end
        end
        e.ok    = found;
        e.fault = !found;
        if (!found && is_walk && side) begin
            e.status  = {wr, 1'b1};
            model_far = ea;
        end
        e.far = model_far;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic issue(input bit op, input logic [31:0] ea, input bit side,
                         input bit wr, input logic [31:0] lo, input bit spur);
        int k;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_op = op; req_ea = ea; req_data_side = side; req_write = wr;
        req_lo_word = lo; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (busy) begin
            @(negedge clk);
            k++;
            if (spur && k == 3) begin
                req_valid = 1'b1; req_op = 1'b1; req_ea = ea ^ 32'h0040_0000;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic do_walk(input logic [31:0] ea, input bit side, input bit wr,
                           input string tag, input bit spur = 1'b0);
        expect_req(1'b1, ea, side, wr, tag);
        issue(1'b0, ea, side, wr, 32'h0, spur);
    endtask

    task automatic do_insert(input logic [31:0] ea, input logic [31:0] lo, input string tag);
        expect_req(1'b0, ea, 1'b1, 1'b0, tag);
        issue(1'b1, ea, 1'b1, 1'b0, lo, 1'b0);
    endtask

    // Memory model: stalls and response delay from an LFSR
    initial begin
        logic [7:0] lfsr;
        bit          pend;
        logic [31:0] pend_data;
        logic [1:0]  pend_dly;
        lfsr = 8'h5A; pend = 1'b0; pend_data = '0; pend_dly = '0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (pend_dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = pend_data;
                    pend = 1'b0;
                end else begin
                    pend_dly--;
                end
            end
            mem_req_ready = 1'b0;
            if (rst_n && mem_req_valid && !pend && (lfsr[0] | lfsr[3])) begin
                mem_req_ready = 1'b1;
                act_trace.push_back({mem_req_we, mem_req_addr});
                if (mem_req_we) begin
                    mem_q[mem_req_addr] = mem_req_wdata;
                end else begin
                    pend      = 1'b1;
                    pend_data = mrd(mem_req_addr);
                    pend_dly  = lfsr[5:4];
                end
            end
        end
    end

    // Monitor: scoreboard compare on each done
    initial begin
        exp_t  e;
        string t;
        int    na;
        logic [32:0] ea_t, aa_t;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "done without a taken request", 64'(done), 64'h0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(resp_ok == e.ok, t, "resp_ok", 64'(resp_ok), 64'(e.ok));
                    chk(resp_fault == e.fault, t, "resp_fault", 64'(resp_fault), 64'(e.fault));
                    chk(resp_status == e.status, t, "resp_status", 64'(resp_status), 64'(e.status));
                    chk(resp_far == e.far, t, "resp_far", 64'(resp_far), 64'(e.far));
                    if (e.walk && e.ok)
                        chk(resp_pa == e.pa, t, "resp_pa", 64'(resp_pa), 64'(e.pa));
                    na = act_trace.size();
                    chk(na == int'(e.n_acc), t, "access count", 64'(na), 64'(e.n_acc));
                    for (int i = 0; i < int'(e.n_acc); i++) begin
                        ea_t = exp_trace.pop_front();
                        aa_t = (act_trace.size() > 0) ? act_trace.pop_front() : '1;
                        chk(aa_t == ea_t, t, "access {we,addr}", 64'(aa_t), 64'(ea_t));
                    end
                    act_trace.delete();
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        logic [31:0] a_ea, c_ea, d_ea, e_ea, a_slot, c_slot;
        for (int i = 0; i < NUM_SEG; i++) seg_v[i] = 24'h0A5000 + 24'(i * 24'h001357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'h0);
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'h0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'h0);
        chk(resp_far == 32'h0 && resp_status == 2'b0, "R1", "far/status after reset",
            64'({resp_far, resp_status}), 64'h0);

        // R7 zero table register: data-side store fault, no traffic
        tbl_reg = 32'h0;
        do_walk(32'h1234_5678, 1'b1, 1'b1, "R7");

        tbl_reg = 32'h0010_0003;

        // R8 insert into empty table, then R5 walk hit in the same page
        a_ea = 32'h3000_5000;
        do_insert(a_ea, 32'h8765_4E04, "R8");
        a_slot = grp(a_ea, 1'b0);
        chk(mrd(a_slot) == kval(a_ea, 1'b0), "R8", "inserted first word",
            64'(mrd(a_slot)), 64'(kval(a_ea, 1'b0)));
        chk(mrd(a_slot + 4) == 32'h8765_4E04, "R8", "inserted second word",
            64'(mrd(a_slot + 4)), 64'h8765_4E04);
        do_walk(a_ea | 32'h123, 1'b1, 1'b0, "R5");

        // R4 same groups, tag bits differ: full miss, data read fault
        do_walk(a_ea ^ 32'h0400_0000, 1'b1, 1'b0, "R4");
        // R6 instruction-side miss: status zero, far kept
        do_walk(a_ea ^ 32'h0400_0000, 1'b0, 1'b0, "R6");

        // R3 primary group full: insert lands in secondary slot 0
        c_ea = 32'h5000_9000;
        for (int i = 0; i < 8; i++) mem_q[grp(c_ea, 1'b0) + 32'(i * 8)] = 32'hC000_0000 | 32'(i);
        do_insert(c_ea, 32'h0ABCD_204, "R3");
        c_slot = grp(c_ea, 1'b1);
        chk(mrd(c_slot) == kval(c_ea, 1'b1), "R8", "secondary first word with H set",
            64'(mrd(c_slot)), 64'(kval(c_ea, 1'b1)));
        do_walk(c_ea | 32'hFFF, 1'b1, 1'b0, "R4");

        // R9 both groups full: insert fails with no writes
        for (int i = 1; i < 8; i++) mem_q[c_slot + 32'(i * 8)] = 32'hC000_0100 | 32'(i);
        d_ea = c_ea ^ 32'h0400_0000;
        do_insert(d_ea, 32'h1111_1000, "R9");

        // R3 hit at primary slot 3 after invalid and junk slots
        e_ea = 32'h7001_2000;
        mem_q[grp(e_ea, 1'b0) + 0]  = 32'hC000_0200;
        mem_q[grp(e_ea, 1'b0) + 8]  = 32'h0000_0000;
        mem_q[grp(e_ea, 1'b0) + 16] = 32'hC000_0201;
        mem_q[grp(e_ea, 1'b0) + 24] = kval(e_ea, 1'b0);
        mem_q[grp(e_ea, 1'b0) + 28] = 32'h0BEE_F204;
        do_walk(e_ea | 32'hABC, 1'b1, 1'b1, "R3");

        // R10 request raised while busy is ignored
        do_walk(d_ea, 1'b0, 1'b0, "R10", 1'b1);

        // R2 mask field zero: high hash bits drop out of the group address
        tbl_reg = 32'h0020_0000;
        do_walk(32'hF0AB_C000, 1'b1, 1'b1, "R2");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "pending expected results", 64'(exp_q.size()), 64'h0);
        chk(act_trace.size() == 0, "R11", "memory accesses outside a request",
            64'(act_trace.size()), 64'h0);
        finish_run();
    end
endmodule